// File: doc/BRIEF.md
# TLB Duplicate-Entry Scrubber

This block walks a set-associative translation buffer after a request and removes entries that translate the same page twice within one set. Once started, it visits every set in ascending order. It reads the tag of each way through a flat-index read port and keeps a local copy of each tag's page-address field. While it reads, it also accumulates whether any way of the set is valid. A set with no valid way is left untouched and costs only its read cycles.

For a set that has at least one valid way, the block tests every pair of ways, one pair per cycle. The first member of a pair is always the lower way. When the two page fields are equal, the block clears the lower way in the buffer through a flat-index erase port, which zeroes both descriptor halves of that entry. It also zeroes the local copy, so the cleared way takes part in no later match. A local page field of zero never starts a match.

Each removal can be reported as an event carrying the set and both ways, and a silent input mutes these reports. A counter holds the number of entries removed in the last sweep. A one-cycle done pulse marks the end of the sweep.

Top module: `tlb_dup_scrubber`

## Requirements
- R1: After an accepted start, sets are visited from 0 to SETS-1. In each set, ways 0 to WAYS-1 are read one per cycle at flat index set*WAYS+way, with `rd_en_o` high. WAYS may be 2 to 4. Read and erase never occur in the same cycle.
- R2: If no read tag of a set has its valid bit (bit VALID_BIT, 10 by default) set, the set takes exactly WAYS cycles and nothing in it is erased, even when its page fields are equal.
- R3: Only the page field is compared: tag bits at positions PAGE_SHIFT (13 by default) and above. Tags that differ only below bit PAGE_SHIFT, including in the valid bit, count as a match.
- R4: In a set with a valid way, pairs (a,b) with a<b are tested one per cycle, in ascending a and then ascending b. This takes WAYS*(WAYS-1)/2 cycles. On a match, `ers_en_o` is high for that cycle with `ers_idx_o` = set*WAYS+a, and the entry is zeroed.
- R5: A local page field that is zero, either as read or because it was cleared earlier in the set, never starts a match. So three equal ways 0,1,2 lose ways 0 and 1 and keep way 2.
- R6: Each erase raises `dup_vld_o` for exactly that cycle, with `dup_set_o`, `dup_lo_o` = a and `dup_hi_o` = b.
- R7: While `silent_i` is high, `dup_vld_o` stays low. Erasing and counting are unaffected.
- R8: `start_i` is accepted only when the block is idle (neither busy nor signalling done). A start pulse during a sweep changes neither the sweep's length, its erases nor its count.
- R9: `busy_o` is high from the cycle after an accepted start until the last set is handled. `done_o` is then high for exactly one cycle. The total sweep length is SETS*WAYS plus WAYS*(WAYS-1)/2 for each set with a valid way.
- R10: `dup_cnt_o` is cleared by an accepted start and increments once per erase. After a sweep it equals the number of entries removed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Sweep request pulse |
| silent_i | input | 1 | Mutes duplicate events |
| rd_en_o | output | 1 | Tag read strobe |
| rd_idx_o | output | IDX_W | Flat index of the tag being read |
| rd_tag_i | input | TAG_W | Tag at `rd_idx_o`, returned in the same cycle |
| ers_en_o | output | 1 | Erase strobe: zero both descriptors at `ers_idx_o` |
| ers_idx_o | output | IDX_W | Flat index to erase |
| dup_vld_o | output | 1 | Duplicate event valid |
| dup_set_o | output | SET_W | Set of the duplicate |
| dup_lo_o | output | WAY_W | Lower way, the one erased |
| dup_hi_o | output | WAY_W | Higher way, the one kept |
| dup_cnt_o | output | CNT_W | Entries removed in the last sweep |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The hardest case to reach from the ports is a way cleared earlier in the same set meeting a later partner. The stimulus creates it by loading three valid ways of one set with the same page, so that the cleared way must be skipped and the middle way must still match the top one. A second hard case is a set whose ways share a page field but carry no valid bit. This is reached by loading such a set beside valid ones, and the sweep length shows whether the set was skipped. The mid-sweep start pulse is driven from inside the cycle-counting loop, so it lands while the walk is busy.

// File: rtl/tlb_scrub_pkg.sv
// Shared types for the TLB duplicate-entry scrubber.
// Assumes: nothing beyond IEEE 1800-2017.
package tlb_scrub_pkg;

    // Walker phases: idle, reading the ways of a set, scanning pairs, end pulse
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_SCAN = 2'd2,
        ST_DONE = 2'd3
    } scrub_st_e;

endpackage

// File: rtl/tlb_scrub_ctrl.sv
// Sequencer for the scrubber: walks the set and way counters, then the pair
// counters (a,b) with a<b, and raises the one-cycle done state.
// Assumes: SETS >= 2 and 2 <= WAYS <= 4, and any_valid_i is valid while reading.
module tlb_scrub_ctrl
    import tlb_scrub_pkg::*;
#(
    parameter int SETS = 8,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             any_valid_i,
    output scrub_st_e        state_o,
    output logic [SET_W-1:0] set_o,
    output logic [WAY_W-1:0] way_o,
    output logic [WAY_W-1:0] pa_o,
    output logic [WAY_W-1:0] pb_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam logic [SET_W-1:0] LAST_SET = SET_W'(SETS - 1);
    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);
    localparam logic [WAY_W-1:0] PEN_WAY  = WAY_W'(WAYS - 2);

    scrub_st_e        state_q;
    logic [SET_W-1:0] set_q;
    logic [WAY_W-1:0] way_q, pa_q, pb_q;

    // Phase and counter update for the walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            set_q   <= '0;
            way_q   <= '0;
            pa_q    <= '0;
            pb_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q <= ST_READ;
                    set_q   <= '0;
                    way_q   <= '0;
                end
                ST_READ: begin
                    if (way_q != LAST_WAY) begin
                        way_q <= way_q + 1'b1;
                    end else if (any_valid_i) begin
                        state_q <= ST_SCAN;
                        pa_q    <= '0;
                        pb_q    <= WAY_W'(1);
                    end else if (set_q == LAST_SET) begin
                        state_q <= ST_DONE;
                    end else begin
                        set_q <= set_q + 1'b1;
                        way_q <= '0;
                    end
                end
                ST_SCAN: begin
                    if (pb_q != LAST_WAY) begin
                        pb_q <= pb_q + 1'b1;
                    end else if (pa_q != PEN_WAY) begin
                        pa_q <= pa_q + 1'b1;
                        pb_q <= pa_q + WAY_W'(2);
                    end else if (set_q == LAST_SET) begin
                        state_q <= ST_DONE;
                    end else begin
                        state_q <= ST_READ;
                        set_q   <= set_q + 1'b1;
                        way_q   <= '0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign set_o   = set_q;
    assign way_o   = way_q;
    assign pa_o    = pa_q;
    assign pb_o    = pb_q;
    assign busy_o  = (state_q == ST_READ) || (state_q == ST_SCAN);
    assign done_o  = (state_q == ST_DONE);

    // R9: done lasts one cycle and the walker is idle afterwards
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R8: a start while busy does not send the walk back to set 0
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && set_q != '0) |=> (set_q != '0 || done_o));
endmodule

// File: rtl/tlb_scrub_tagbuf.sv
// Local copy of one set's page fields, the valid accumulator and the pair
// comparator. A killed way reads back as zero and a zero field never matches.
// Assumes: loads arrive way 0 first; kill only targets a stored way.
module tlb_scrub_tagbuf #(
    parameter int WAYS       = 4,
    parameter int TAG_W      = 32,
    parameter int PAGE_SHIFT = 13,
    parameter int VALID_BIT  = 10,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en_i,
    input  logic [WAY_W-1:0] ld_way_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             kill_en_i,
    input  logic [WAY_W-1:0] kill_way_i,
    input  logic [WAY_W-1:0] pa_i,
    input  logic [WAY_W-1:0] pb_i,
    output logic             any_valid_o,
    output logic             match_o
);
    localparam logic [TAG_W-1:0] PAGE_MASK = ~((TAG_W'(1) << PAGE_SHIFT) - TAG_W'(1));

    logic [TAG_W-1:0] page_q [WAYS];
    logic             vacc_q;
    logic             first_ld;

    // Valid OR of the set so far, restarted by the load of way 0
    assign first_ld    = ld_en_i && (ld_way_i == '0);
    assign any_valid_o = (ld_en_i && tag_i[VALID_BIT]) || (vacc_q && !first_ld);

    // Keep the accumulated valid flag across the read cycles
    always_ff @(posedge clk) begin
        if (!rst_n)       vacc_q <= 1'b0;
        else if (ld_en_i) vacc_q <= any_valid_o;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        // Capture the masked page field, or zero it when the way is erased
        always_ff @(posedge clk) begin
            if (!rst_n)
                page_q[w] <= '0;
            else if (ld_en_i && ld_way_i == WAY_W'(w))
                page_q[w] <= tag_i & PAGE_MASK;
            else if (kill_en_i && kill_way_i == WAY_W'(w))
                page_q[w] <= '0;
        end
    end

    // Pair test: the first member must hold a non-zero page field
    assign match_o = (page_q[pa_i] != '0) && (page_q[pa_i] == page_q[pb_i]);

    // R5: an erase never targets a way whose local field is already zero
    assert_kill_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        kill_en_i |-> (page_q[kill_way_i] != '0));

    // R5: a killed way holds zero in the following cycle
    assert_killed_is_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_en_i && !ld_en_i) |=> (page_q[$past(kill_way_i)] == '0));
endmodule

// File: rtl/tlb_dup_scrubber.sv
// TLB duplicate-entry scrubber top: joins the sequencer and the tag buffer,
// forms flat indices, drives the erase and event outputs and counts removals.
// Assumes: the read port returns rd_tag_i in the same cycle as rd_idx_o, and
// the buffer zeroes both descriptor halves when ers_en_o is high at a clock edge.
module tlb_dup_scrubber
    import tlb_scrub_pkg::*;
#(
    parameter int SETS       = 8,
    parameter int WAYS       = 4,
    parameter int TAG_W      = 32,
    parameter int PAGE_SHIFT = 13,
    parameter int VALID_BIT  = 10,
    localparam int SET_W    = $clog2(SETS),
    localparam int WAY_W    = $clog2(WAYS),
    localparam int IDX_W    = $clog2(SETS * WAYS),
    localparam int MAX_DUPS = SETS * (WAYS - 1),
    localparam int CNT_W    = $clog2(MAX_DUPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             silent_i,
    output logic             rd_en_o,
    output logic [IDX_W-1:0] rd_idx_o,
    input  logic [TAG_W-1:0] rd_tag_i,
    output logic             ers_en_o,
    output logic [IDX_W-1:0] ers_idx_o,
    output logic             dup_vld_o,
    output logic [SET_W-1:0] dup_set_o,
    output logic [WAY_W-1:0] dup_lo_o,
    output logic [WAY_W-1:0] dup_hi_o,
    output logic [CNT_W-1:0] dup_cnt_o,
    output logic             busy_o,
    output logic             done_o
);
    scrub_st_e        state;
    logic [SET_W-1:0] set_cur;
    logic [WAY_W-1:0] way_cur, pa, pb;
    logic             any_valid, match, hit, start_ok;
    logic [IDX_W-1:0] set_base;
    logic [CNT_W-1:0] cnt_q;

    tlb_scrub_ctrl #(.SETS(SETS), .WAYS(WAYS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .any_valid_i(any_valid),
        .state_o    (state),
        .set_o      (set_cur),
        .way_o      (way_cur),
        .pa_o       (pa),
        .pb_o       (pb),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    tlb_scrub_tagbuf #(
        .WAYS(WAYS), .TAG_W(TAG_W), .PAGE_SHIFT(PAGE_SHIFT), .VALID_BIT(VALID_BIT)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_en_i    (rd_en_o),
        .ld_way_i   (way_cur),
        .tag_i      (rd_tag_i),
        .kill_en_i  (hit),
        .kill_way_i (pa),
        .pa_i       (pa),
        .pb_i       (pb),
        .any_valid_o(any_valid),
        .match_o    (match)
    );

    // Flat addressing: set*WAYS + way
    assign set_base  = IDX_W'(set_cur) * IDX_W'(WAYS);
    assign rd_en_o   = (state == ST_READ);
    assign rd_idx_o  = set_base + IDX_W'(way_cur);

    // Erase the lower way of a matching pair; report unless muted
    assign hit       = (state == ST_SCAN) && match;
    assign ers_en_o  = hit;
    assign ers_idx_o = set_base + IDX_W'(pa);
    assign dup_vld_o = hit && !silent_i;
    assign dup_set_o = set_cur;
    assign dup_lo_o  = pa;
    assign dup_hi_o  = pb;

    // Removal counter, cleared when a sweep is accepted
    assign start_ok = start_i && (state == ST_IDLE);
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (start_ok) cnt_q <= '0;
        else if (hit)      cnt_q <= cnt_q + 1'b1;
    end
    assign dup_cnt_o = cnt_q;

    // R1: read and erase never share a cycle
    assert_rd_ers_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_o && ers_en_o));

    // R2: an erase only happens in a set that holds a valid way
    assert_erase_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ers_en_o |-> any_valid);

    // R4: the erased way is always the lower member of the pair
    assert_pair_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ers_en_o |-> (dup_lo_o < dup_hi_o));

    // R7: muted events never appear
    assert_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        silent_i |-> !dup_vld_o);

    // R6: every reported event coincides with an erase
    assert_event_has_erase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dup_vld_o |-> ers_en_o);

    // R10: the count never exceeds the removable entries
    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dup_cnt_o <= CNT_W'(MAX_DUPS));

    // R8: a start during a sweep does not clear the count
    assert_busy_start_keeps_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (dup_cnt_o >= $past(dup_cnt_o)));
endmodule

// File: tb/sim_tlb_dup_scrubber.sv
// Scoreboard bench: a driver task models the sweep on a copy of the TLB and
// queues the expected events; a monitor pops and compares each reported event.
module sim_tlb_dup_scrubber;
    localparam int SETS = 8, WAYS = 4, TAG_W = 32, PS = 13, VB = 10;
    localparam int N     = SETS * WAYS;
    localparam int PAIRS = WAYS * (WAYS - 1) / 2;
    localparam int IDX_W = $clog2(N);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int CNT_W = $clog2(SETS * (WAYS - 1) + 1);

    logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, silent_i = 1'b0;
    logic             rd_en_o, ers_en_o, dup_vld_o, busy_o, done_o;
    logic [IDX_W-1:0] rd_idx_o, ers_idx_o;
    logic [TAG_W-1:0] rd_tag_i;
    logic [SET_W-1:0] dup_set_o;
    logic [WAY_W-1:0] dup_lo_o, dup_hi_o;
    logic [CNT_W-1:0] dup_cnt_o;

    logic [TAG_W-1:0] mem [N];
    logic [TAG_W-1:0] exp_mem [N];
    int exp_q [$];
    int n_tests = 0, n_fail = 0, cyc = 0;
    bit timed_out = 0;

    always #2.5 clk = ~clk;

    tlb_dup_scrubber #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W),
                       .PAGE_SHIFT(PS), .VALID_BIT(VB)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .silent_i(silent_i),
        .rd_en_o(rd_en_o), .rd_idx_o(rd_idx_o), .rd_tag_i(rd_tag_i),
        .ers_en_o(ers_en_o), .ers_idx_o(ers_idx_o), .dup_vld_o(dup_vld_o),
        .dup_set_o(dup_set_o), .dup_lo_o(dup_lo_o), .dup_hi_o(dup_hi_o),
        .dup_cnt_o(dup_cnt_o), .busy_o(busy_o), .done_o(done_o));

    // TLB model: same-cycle read, erase at the clock edge
    assign rd_tag_i = mem[rd_idx_o];
    always @(posedge clk) if (ers_en_o) mem[ers_idx_o] <= '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compare each reported duplicate with the scoreboard head (R6)
    always @(negedge clk) begin
        if (rst_n && dup_vld_o) begin
            int got;
            got = int'(dup_set_o) * 256 + int'(dup_lo_o) * 16 + int'(dup_hi_o);
            if (exp_q.size() == 0) check(0, "R6/R7 unexpected event", got, -1);
            else begin
                int e;
                e = exp_q.pop_front();
                check(got == e, "R6 event set/lo/hi", got, e);
            end
        end
    end

    function automatic logic [TAG_W-1:0] mk(input int page, input int low);
        return (TAG_W'(page) << PS) | TAG_W'(low);
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < N; i++) mem[i] = '0;
    endtask

    // Driver: reference sweep on a copy, then run the block and compare
    task automatic run(input string tag, input bit silent, input bit poke);
        int exp_lat, exp_cnt, lat, bad;
        logic [TAG_W-1:0] pg [WAYS];
        exp_lat = N; exp_cnt = 0;
        for (int i = 0; i < N; i++) exp_mem[i] = mem[i];
        for (int s = 0; s < SETS; s++) begin
            bit v;
            v = 0;
            for (int w = 0; w < WAYS; w++) begin
                pg[w] = exp_mem[s*WAYS+w] & ~((TAG_W'(1) << PS) - 1);
                v |= exp_mem[s*WAYS+w][VB];
            end
            if (!v) continue;
            exp_lat += PAIRS;
            for (int a = 0; a < WAYS - 1; a++)
                for (int b = a + 1; b < WAYS; b++)
                    if (pg[a] != '0 && pg[a] == pg[b]) begin
                        pg[a] = '0;
                        exp_mem[s*WAYS+a] = '0;
                        exp_cnt++;
                        if (!silent) exp_q.push_back(s * 256 + a * 16 + b);
                    end
        end
        silent_i = silent;
        @(negedge clk); start_i = 1'b1;
        @(posedge clk);
        lat = 0;
        forever begin
            @(negedge clk);
            start_i = (poke && lat == 5);
            if (done_o || lat > 5000) break;
            @(posedge clk); lat++;
        end
        start_i = 1'b0;
        check(lat == exp_lat, {"R9/R2/R4 sweep length ", tag}, lat, exp_lat);
        check(int'(dup_cnt_o) == exp_cnt, {"R10 count ", tag}, int'(dup_cnt_o), exp_cnt);
        @(negedge clk);
        check(!done_o && !busy_o, {"R9 single done pulse ", tag}, int'(done_o), 0);
        bad = 0;
        for (int i = 0; i < N; i++) if (mem[i] !== exp_mem[i]) bad++;
        check(bad == 0, {"R4/R5/R3 TLB contents ", tag}, bad, 0);
        check(exp_q.size() == 0, {"R6 events outstanding ", tag}, exp_q.size(), 0);
        exp_q.delete();
        silent_i = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            check(!busy_o, "R8 no second sweep after mid-run start", int'(busy_o), 0);
        end
    endtask

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check(!busy_o && !done_o && !rd_en_o && !ers_en_o && dup_cnt_o == 0,
              "R9 reset state", int'(busy_o), 0);

        // R2: invalid set with equal pages is skipped
        clear_mem();
        mem[2*WAYS+0] = mk(5, 0); mem[2*WAYS+1] = mk(5, 3);
        run("R2 empty", 0, 0);

        // R1/R4/R6: pairs in first and last set
        clear_mem();
        mem[0] = mk(7, 1 << VB); mem[3] = mk(7, 1 << VB);
        mem[7*WAYS+1] = mk(9, 1 << VB); mem[7*WAYS+2] = mk(9, 1 << VB);
        mem[7*WAYS+3] = mk(10, 1 << VB);
        run("R1 first/last set", 0, 0);

        // R5: triple match keeps only the top way
        clear_mem();
        for (int w = 0; w < 3; w++) mem[3*WAYS+w] = mk(12, 1 << VB);
        mem[3*WAYS+3] = mk(13, 1 << VB);
        run("R5 triple", 0, 0);

        // R3/R5: masked low bits, zero pages, invalid partners in a valid set
        clear_mem();
        mem[4*WAYS+0] = mk(20, 1 << VB);
        mem[4*WAYS+2] = mk(21, 0); mem[4*WAYS+3] = mk(21, 0);
        mem[5*WAYS+0] = mk(0, 1 << VB); mem[5*WAYS+1] = mk(0, 1 << VB);
        mem[6*WAYS+0] = mk(30, (1 << VB) | 5); mem[6*WAYS+1] = mk(30, 'h7A);
        run("R3 masking", 0, 0);

        // R7: silent mode still erases and counts
        clear_mem();
        mem[0] = mk(7, 1 << VB); mem[3] = mk(7, 1 << VB);
        mem[1*WAYS+0] = mk(8, 1 << VB); mem[1*WAYS+1] = mk(8, 1 << VB);
        run("R7 silent", 1, 0);

        // R8: start pulse during a sweep
        clear_mem();
        for (int w = 0; w < 3; w++) mem[1*WAYS+w] = mk(40, 1 << VB);
        run("R8 mid-run start", 0, 1);

        // R10: count cleared on the next start
        clear_mem();
        run("R10 clear", 0, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 100000 && !timed_out) begin
            timed_out = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule